// File: doc/BRIEF.md
# Interrupt Trigger Sense and Pending Unit

This block sits in front of an interrupt arbiter. It takes a vector of raw interrupt source lines, brings each one into the local clock domain, and turns it into a pending flag. How the flag reacts to its line depends on the source's trigger mode. There are four modes: level, falling edge, rising edge and both edges. The arbiter consumes the flags, and it also receives a one-cycle strobe each time a flag goes from clear to set, so it can try an immediate request.

Sources at numbers `PIN_BASE` and above are external pins. Each pin has its own mode register that software can write and read. Every other source has a fixed mode, chosen by the `LEVEL_INIT` parameter: rising edge when its bit is 0, level when its bit is 1. The same parameter also sets the reset mode of each pin.

A small byte-wide register port provides three things:
- software clearing of edge-type pending flags;
- read-back of the flags and of the pin modes;
- a software interrupt register, which fires a single-cycle pulse when written.

Top module: `irq_sense_unit`

## Requirements
- R1: A change on `src_i[n]` passes through two synchronizer flops. It can first affect `pend_o[n]` just after the third rising clock edge that samples it.
- R2: In level mode (code 00), `pend_o[n]` is high in each cycle where the synchronized input was high at the previous edge, and low in each cycle where it was low.
- R3: In rising-edge mode (code 10), a 0-to-1 transition of the synchronized input, compared against its stored previous value, sets the flag. The flag then stays set after the input falls.
- R4: In falling-edge mode (code 01), a 1-to-0 transition sets the flag, and a rising transition does not.
- R5: In both-edge mode (code 11), any transition sets the flag.
- R6: The mode register of pin k sits at address 0x100+k and controls source `PIN_BASE`+k.
  - Bits 3:2 hold the mode code.
  - A write takes effect for the following edge.
  - A read returns the mode in bits 3:2 and zeros in all other bits.
- R7: After reset, sources whose `LEVEL_INIT` bit is 1 are in level mode, and all other sources are in rising-edge mode. A pin's mode register therefore reads 0x00 or 0x08.
- R8: Writing 0x00 to address n (where n < `N_SRC`) clears pending flag n, provided source n is not in level mode. Any nonzero data written there is ignored.
- R9: Reading address n returns pending flag n in bit 0, with bits 7:1 always zero.
- R10: A write to address 0x200 with data bit 0 set makes `swi_o` high for exactly the next cycle. Writes with bit 0 clear produce no pulse, and reads of 0x200 return 0.
- R11: `new_o[n]` is high for exactly the first cycle in which `pend_o[n]` is high after being low.
- R12: When an edge event and a software clear reach the same source at the same edge, the event wins. The flag ends up set, and if it was already set, no `new_o` strobe is produced.
- R13: While reset is held, and in the first cycle after it is released, all flags, strobes and `swi_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from `addr_i` |
| pend_o | output | N_SRC | Pending flags to the arbiter |
| new_o | output | N_SRC | One-cycle strobes marking a newly set flag |
| swi_o | output | 1 | Software interrupt pulse |

## Verification
Two functions can land on the same source at the same clock edge: an edge event that sets a flag, and a software write of zero that clears it. The bench provokes this by raising a line and then timing the clear write so that it is sampled at the exact edge where the synchronized transition is detected. It does this once on a flag that is already set and once on a flag that is clear. The bench judges the result by the flag read back afterwards and by whether the new-event strobe appeared, both compared cycle by cycle against its own model. A long randomized phase then mixes line toggles with clears, mode writes and software interrupt writes, so that further collisions occur.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 8;

  typedef enum logic [1:0] {
    MODE_LVL  = 2'b00,
    MODE_FALL = 2'b01,
    MODE_RISE = 2'b10,
    MODE_BOTH = 2'b11
  } mode_e;

  localparam logic [1:0]        PAGE_PEND = 2'd0;
  localparam logic [1:0]        PAGE_PIN  = 2'd1;
  localparam logic [ADDR_W-1:0] SWI_ADDR  = 10'h200;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_sense_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  smp_i,
  input  mode_e mode_i,
  input  logic  clr_i,
  output logic  pend_o,
  output logic  new_o
);
  logic prev_q, pend_q, new_q;
  logic evt, nxt;

  always_comb begin
    unique case (mode_i)
      MODE_FALL: evt = prev_q & ~smp_i;
      MODE_RISE: evt = ~prev_q & smp_i;
      MODE_BOTH: evt = prev_q ^ smp_i;
      default:   evt = 1'b0;
    endcase
    // level mode tracks the input; edge flags hold until cleared, event beats clear
    if (mode_i == MODE_LVL) nxt = smp_i;
    else                    nxt = evt | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      new_q  <= 1'b0;
    end else begin
      prev_q <= smp_i;
      pend_q <= nxt;
      new_q  <= nxt & ~pend_q;
    end
  end

  assign pend_o = pend_q;
  assign new_o  = new_q;
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
  import irq_sense_pkg::*;
#(
  parameter int               N_SRC      = 72,
  parameter int               PIN_BASE   = 64,
  parameter logic [N_SRC-1:0] LEVEL_INIT = 72'h02_0000_0000_0000_0006
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic [N_SRC-1:0]  new_o,
  output logic              swi_o
);
  localparam int NUM_PINS = N_SRC - PIN_BASE;

  logic [N_SRC-1:0] smp;
  mode_e            mode [N_SRC];
  logic [1:0]       page;
  logic [IDX_W-1:0] idx;
  logic             wr_pend, wr_pin, wr_swi, swi_q;

  assign page    = addr_i[9:8];
  assign idx     = addr_i[IDX_W-1:0];
  assign wr_pend = wr_en_i && (page == PAGE_PEND);
  assign wr_pin  = wr_en_i && (page == PAGE_PIN);
  assign wr_swi  = wr_en_i && (addr_i == SWI_ADDR);

  irq_sync #(.W(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (smp)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic clr;
    assign clr = wr_pend && (idx == IDX_W'(i)) && (wdata_i == '0);

    if (i >= PIN_BASE) begin : g_pin
      mode_e mode_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mode_q <= LEVEL_INIT[i] ? MODE_LVL : MODE_RISE;
        else if (wr_pin && (idx == IDX_W'(i - PIN_BASE)))
          mode_q <= mode_e'(wdata_i[3:2]);
      end
      assign mode[i] = mode_q;
    end else begin : g_fix
      assign mode[i] = LEVEL_INIT[i] ? MODE_LVL : MODE_RISE;
    end

    irq_sense_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (smp[i]),
      .mode_i(mode[i]),
      .clr_i (clr),
      .pend_o(pend_o[i]),
      .new_o (new_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) swi_q <= 1'b0;
    else         swi_q <= wr_swi && wdata_i[0];
  end
  assign swi_o = swi_q;

  always_comb begin
    rdata_o = '0;
    if (page == PAGE_PEND) begin
      for (int i = 0; i < N_SRC; i++)
        if (idx == IDX_W'(i)) rdata_o = {{(DATA_W-1){1'b0}}, pend_o[i]};
    end else if (page == PAGE_PIN) begin
      for (int k = 0; k < NUM_PINS; k++)
        if (idx == IDX_W'(k)) rdata_o = {4'b0000, mode[PIN_BASE+k], 2'b00};
    end
  end
endmodule

// File: rtl/irq_sense_unit_chk.sv
module irq_sense_unit_chk
  import irq_sense_pkg::*;
#(
  parameter int               N_SRC      = 72,
  parameter int               PIN_BASE   = 64,
  parameter logic [N_SRC-1:0] LEVEL_INIT = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  pend_o,
  input logic [N_SRC-1:0]  new_o,
  input logic              swi_o,
  input logic [N_SRC-1:0]  smp_i
);
  AST_NEW_IS_FIRST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_o == (pend_o & ~$past(pend_o))); // R11

  AST_SWI_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_o |-> $past(wr_en_i && addr_i == SWI_ADDR && wdata_i[0])); // R10

  AST_SWI_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == SWI_ADDR && wdata_i[0]) |=> swi_o); // R10

  always_comb begin
    if (rst_ni && addr_i[9:8] == PAGE_PEND)
      AST_PEND_READ_NARROW: assert (rdata_o[7:1] == '0); // R9
    if (rst_ni && addr_i == SWI_ADDR)
      AST_SWI_READ_ZERO: assert (rdata_o == '0); // R10
  end

  for (genvar i = 0; i < PIN_BASE; i++) begin : g_fix
    if (LEVEL_INIT[i]) begin : g_lvl
      AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o[i] == $past(smp_i[i])); // R2
    end else begin : g_edge
      AST_RISE_NEEDS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o[i] && !$past(pend_o[i])) |-> $past(smp_i[i])); // R3
      AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(wr_en_i && addr_i == ADDR_W'(i) && wdata_i == '0 && !smp_i[i])
          |-> !pend_o[i]); // R8
    end
  end
endmodule

bind irq_sense_unit irq_sense_unit_chk #(
  .N_SRC(N_SRC), .PIN_BASE(PIN_BASE), .LEVEL_INIT(LEVEL_INIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pend_o (pend_o),
  .new_o  (new_o),
  .swi_o  (swi_o),
  .smp_i  (smp)
);

// File: tb/irq_sense_unit_bench.sv
`timescale 1ns/1ps
module irq_sense_unit_bench;
  localparam int N  = 72;
  localparam int PB = 64;
  localparam int NP = N - PB;
  localparam logic [N-1:0] LVL = 72'h02_0000_0000_0000_0006;

  logic         clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic         wr_en = 0;
  logic [9:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic [N-1:0] pend, newv;
  logic         swi;

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_sense_unit #(.N_SRC(N), .PIN_BASE(PB), .LEVEL_INIT(LVL)) u_irq_sense_unit (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend), .new_o(newv), .swi_o(swi)
  );

  // behavioural reference: two-stage delay queue plus per-source state
  logic [N-1:0] dq[$];
  bit m_prev[N], m_pend[N], m_new[N], m_swi;
  int m_mode[N];

  task automatic model_reset();
    dq = '{};
    dq.push_back('0);
    dq.push_back('0);
    m_swi = 0;
    for (int i = 0; i < N; i++) begin
      m_prev[i] = 0; m_pend[i] = 0; m_new[i] = 0;
      m_mode[i] = LVL[i] ? 0 : 2;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      logic [N-1:0] s;
      s = dq[0];
      for (int i = 0; i < N; i++) begin
        bit ev, nx, clr;
        case (m_mode[i])
          1: ev = m_prev[i] && !s[i];
          2: ev = !m_prev[i] && s[i];
          3: ev = m_prev[i] != s[i];
          default: ev = 0;
        endcase
        clr = wr_en && addr == 10'(i) && wdata == 0;
        if (m_mode[i] == 0) nx = s[i];
        else nx = ev || (m_pend[i] && !clr);
        m_new[i]  = nx && !m_pend[i];
        m_pend[i] = nx;
        m_prev[i] = s[i];
      end
      if (wr_en && addr >= 10'h100 && addr < 10'h100 + 10'(NP))
        m_mode[PB + int'(addr) - 256] = int'(wdata[3:2]);
      m_swi = wr_en && addr == 10'h200 && wdata[0];
      void'(dq.pop_front());
      dq.push_back(src);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        chk($sformatf("R1 R2 R3 R4 R5 R12 pend[%0d]", i), int'(pend[i]), int'(m_pend[i]));
        chk($sformatf("R11 new[%0d]", i), int'(newv[i]), int'(m_new[i]));
      end
      chk("R10 swi", int'(swi), int'(m_swi));
    end
  end

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, input int exp, input string tag);
    @(negedge clk); #1;
    wr_en = 0; addr = a;
    #1 chk(tag, int'(rdata), exp);
  endtask

  task automatic setsrc(input int i, input bit v);
    @(negedge clk); #1 src[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    model_reset();
    src = '1;
    repeat (3) @(negedge clk);
    chk("R13 pend in reset", int'(pend != 0), 0);
    chk("R13 swi in reset", int'(swi), 0);
    src = '0;
    #1 rst_n = 1;
    @(negedge clk);
    chk("R13 pend after reset", int'(pend != 0), 0);
    rd(10'h100, 8'h08, "R7 pin0 rise at reset");
    rd(10'h101, 8'h00, "R7 pin1 level at reset");

    // R1 latency on level source 1
    setsrc(1, 1);
    @(negedge clk); chk("R1 edge1", int'(pend[1]), 0);
    @(negedge clk); chk("R1 edge2", int'(pend[1]), 0);
    @(negedge clk); chk("R1 edge3", int'(pend[1]), 1);
    wr(10'h001, 8'h00);
    idle(2);
    rd(10'h001, 1, "R8 level not cleared");
    setsrc(1, 0); idle(4);
    rd(10'h001, 0, "R2 level drops");

    // R3 rising on fixed source 10
    setsrc(10, 1); setsrc(10, 0); idle(5);
    rd(10'h00a, 1, "R3 rise held");
    wr(10'h00a, 8'h01); idle(1);
    rd(10'h00a, 1, "R8 nonzero write ignored");
    wr(10'h00a, 8'h00); idle(1);
    rd(10'h00a, 0, "R8 clear edge flag");
    rd(10'h00a, 0, "R9 narrow read");

    // R4/R6 falling on pin 0
    wr(10'h100, 8'h04);
    rd(10'h100, 8'h04, "R6 readback fall");
    setsrc(64, 1); idle(5);
    chk("R4 rise ignored", int'(pend[64]), 0);
    setsrc(64, 0); idle(5);
    chk("R4 fall sets", int'(pend[64]), 1);
    // R5 both edges on pin 2
    wr(10'h102, 8'hFF);
    rd(10'h102, 8'h0C, "R6 readback both");
    setsrc(66, 1); idle(5);
    chk("R5 rise sets", int'(pend[66]), 1);
    wr(10'h042, 8'h00); idle(2);
    chk("R8 clear pin", int'(pend[66]), 0);
    setsrc(66, 0); idle(5);
    chk("R5 fall sets", int'(pend[66]), 1);
    // pin 0 to level
    wr(10'h100, 8'h00);
    rd(10'h100, 8'h00, "R6 readback level");
    setsrc(64, 1); idle(5);
    chk("R2 pin level high", int'(pend[64]), 1);
    setsrc(64, 0); idle(5);
    chk("R2 pin level low", int'(pend[64]), 0);

    // R12 coincidence, flag already set
    setsrc(10, 1); setsrc(10, 0); idle(4);
    setsrc(10, 1); @(negedge clk);
    wr(10'h00a, 8'h00); idle(1);
    rd(10'h00a, 1, "R12 event beats clear (set)");
    // R12 coincidence, flag clear
    setsrc(12, 1); @(negedge clk);
    wr(10'h00c, 8'h00); idle(1);
    rd(10'h00c, 1, "R12 event beats clear (clear)");

    // R10 software pulse
    wr(10'h200, 8'h01); idle(1);
    wr(10'h200, 8'h02); idle(2);
    rd(10'h200, 0, "R10 read zero");

    // randomized mix
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk); #1;
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 9) == 0) src[i] = ~src[i];
      wr_en = 0;
      case ($urandom_range(0, 7))
        0: begin wr_en = 1; addr = 10'($urandom_range(0, N-1)); wdata = 8'($urandom_range(0, 1)); end
        1: begin wr_en = 1; addr = 10'h100 + 10'($urandom_range(0, NP-1)); wdata = 8'($urandom_range(0, 255)); end
        2: begin wr_en = 1; addr = 10'h200; wdata = 8'($urandom_range(0, 3)); end
        default: addr = 10'($urandom_range(0, N-1));
      endcase
    end
    @(negedge clk); #1 wr_en = 0;
    idle(4);
    for (int k = 0; k < NP; k++)
      rd(10'h100 + 10'(k), m_mode[PB+k] << 2, "R6 final mode");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule